// File: doc/BRIEF.md
# Processor Reset and Wait-Idle Controller

This block sequences a processor core through its reset and through the idle state that follows a wait-type instruction. The raw external reset pin is brought through a two-flop synchronizer. The block then checks how long the pulse lasts. A pulse that stays high for fewer than the minimum number of clocks is dropped and changes nothing. A pulse that is long enough halts the core. While the core is halted, the block presents the initial register values and holds a load enable on them. It flushes the prefetch queue once when the reset is accepted. When the pin goes low again, it issues a single start-fetch strobe at the reset vector.

A wait strobe from the decoder stalls the core until the synchronized test input reads low. A pending interrupt also ends this idle state so that the interrupt can be taken. After such an exit, the core stalls again only if the decoder issues a new wait strobe. An accepted reset overrides the idle state.

The block comes out of its own power-up reset in the halted state. From there it follows the same release path as a pin reset.

Top module: `rst_wait_ctrl`

## Requirements
- R1: The reset pin is accepted only after its synchronized level has been high for MIN_RST_CYCLES consecutive clocks. With the defaults (4 clocks, 2 sync flops), the core stall rises on the 6th rising edge after the first edge that samples the pin high.
- R2: A pin pulse sampled high on fewer than MIN_RST_CYCLES edges is ignored. A running core stays unstalled, an idling core stays stalled, and no queue flush occurs.
- R3: While halted, core_stall and arch_load are both 1. The value outputs are: flags 0000h, pointer 0000h, code segment FFFFh, and data, stack and extra segments 0000h.
- R4: queue_flush is high for exactly one cycle, in the cycle in which the halt begins.
- R5: The pin is sampled low on some edge. On the 3rd edge counted from that one, the core leaves the halt. fetch_start is then high for one cycle, core_stall drops, and fetch_addr equals code segment × 16 + pointer = FFFF0h.
- R6: wait_req sampled high while running, with the synchronized test level high, stalls the core from the next cycle.
- R7: In idle, the test pin is sampled low on some edge. The stall drops on the 3rd edge counted from that one.
- R8: In idle, irq_pending sampled high drops the stall at that edge. The core does not stall again until a new wait_req is given.
- R9: wait_req given while the synchronized test level is already low causes no stall.
- R10: An accepted reset overrides the idle state. After release the core runs unstalled, not idle, and wait_req given during the halt has no effect.
- R11: After sys_rst_n rises with the pin low, the core is halted. The release of R5 follows, 3 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| sys_rst_n | input | 1 | Asynchronous power-up reset of this block, active low |
| rst_pin | input | 1 | Raw external processor reset, active high, asynchronous |
| test_pin | input | 1 | Raw test input; a low level ends the wait idle |
| wait_req | input | 1 | One-cycle strobe from the decoder for a wait-type instruction |
| irq_pending | input | 1 | An interrupt is waiting for service |
| flags_init | output | 16 | Flags value to load |
| ip_init | output | 16 | Instruction pointer value to load |
| cs_init | output | 16 | Code segment value to load |
| ds_init | output | 16 | Data segment value to load |
| ss_init | output | 16 | Stack segment value to load |
| es_init | output | 16 | Extra segment value to load |
| arch_load | output | 1 | Hold the architectural registers at the values above |
| queue_flush | output | 1 | One-cycle pulse that empties the prefetch queue |
| fetch_start | output | 1 | One-cycle strobe that starts the first fetch |
| fetch_addr | output | 20 | Physical address of the first fetch |
| core_stall | output | 1 | Core must not advance |

## Verification
The bench builds the block with its default parameters: a minimum pulse of 4 clocks and 2 synchronizer flops. It derives every edge count it waits for from these two values. With them, a 3-clock pulse and a 4-clock pulse differ by one clock, so the bench can show the exact edge at which a pulse changes from ignored to accepted. Both limits are tested: a pulse one clock short during run and during idle, and a pulse of exactly the minimum length.

// File: rtl/rwc_pkg.sv
package rwc_pkg;

  localparam int WORD_W = 16;
  localparam int PHYS_W = 20;

  typedef enum logic [1:0] {
    ST_HALT = 2'd0,
    ST_RUN  = 2'd1,
    ST_IDLE = 2'd2
  } ctl_state_t;

  localparam logic [WORD_W-1:0] FLAGS_INIT_VAL = 16'h0000;
  localparam logic [WORD_W-1:0] IP_INIT_VAL    = 16'h0000;
  localparam logic [WORD_W-1:0] CS_INIT_VAL    = 16'hFFFF;
  localparam logic [WORD_W-1:0] DS_INIT_VAL    = 16'h0000;
  localparam logic [WORD_W-1:0] SS_INIT_VAL    = 16'h0000;
  localparam logic [WORD_W-1:0] ES_INIT_VAL    = 16'h0000;

  // segment shifted by one nibble, plus the offset
  function automatic logic [PHYS_W-1:0] phys_addr(input logic [WORD_W-1:0] seg,
                                                  input logic [WORD_W-1:0] off);
    logic [PHYS_W-1:0] seg_w;
    logic [PHYS_W-1:0] off_w;
    seg_w = {seg, 4'h0};
    off_w = {{(PHYS_W-WORD_W){1'b0}}, off};
    return seg_w + off_w;
  endfunction

endpackage

// File: rtl/rwc_sync.sv
module rwc_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES:0] taps;

  assign taps[0] = d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= RST_VAL;
        else        stage_q <= taps[i];
      end
      assign taps[i+1] = stage_q;
    end
  endgenerate

  assign q = taps[STAGES];

endmodule

// File: rtl/rwc_qualifier.sv
module rwc_qualifier #(
  parameter int MIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic accept
);

  localparam int CNT_W = $clog2(MIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ACC = CNT_W'(MIN_CYCLES - 1);

  logic [CNT_W-1:0] hi_cnt;

  // the pulse becomes valid on the edge that completes MIN_CYCLES high samples
  assign accept = lvl && (hi_cnt == CNT_ACC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hi_cnt <= '0;
    else if (!lvl)              hi_cnt <= '0;
    else if (hi_cnt != CNT_SAT) hi_cnt <= hi_cnt + 1'b1;
  end

  // R1
  accept_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);

  generate
    if (MIN_CYCLES > 1) begin : g_len_chk
      // R2
      accept_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hi_cnt != '0) |-> $past(lvl));
    end
  endgenerate

endmodule

// File: rtl/rwc_fsm.sv
module rwc_fsm
  import rwc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rst_accept,
  input  logic rst_lvl,
  input  logic test_lvl,
  input  logic wait_req,
  input  logic irq_req,
  output logic core_stall,
  output logic arch_load,
  output logic queue_flush,
  output logic fetch_start
);

  ctl_state_t state_q, state_d;
  logic       halt_exit;
  logic       idle_enter;
  logic       wake_by_test;
  logic       wake_by_irq;

  assign halt_exit    = (state_q == ST_HALT) && !rst_lvl && !rst_accept;
  assign idle_enter   = (state_q == ST_RUN)  && wait_req && test_lvl && !rst_accept;
  assign wake_by_test = (state_q == ST_IDLE) && !test_lvl && !rst_accept;
  assign wake_by_irq  = (state_q == ST_IDLE) && test_lvl && irq_req && !rst_accept;

  always_comb begin
    state_d = state_q;
    if (rst_accept)                       state_d = ST_HALT;
    else if (halt_exit)                   state_d = ST_RUN;
    else if (idle_enter)                  state_d = ST_IDLE;
    else if (wake_by_test || wake_by_irq) state_d = ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_HALT;
      queue_flush <= 1'b0;
      fetch_start <= 1'b0;
    end else begin
      state_q     <= state_d;
      queue_flush <= rst_accept;
      fetch_start <= halt_exit;
    end
  end

  assign core_stall = (state_q != ST_RUN);
  assign arch_load  = (state_q == ST_HALT);

  // R4
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    queue_flush |=> !queue_flush);

  // R4
  flush_in_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    queue_flush |-> arch_load);

  // R5
  fetch_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_start) |-> (!core_stall && $past(arch_load)));

  // R6
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_enter |=> (core_stall && !arch_load));

  // R8
  irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_by_irq |=> !core_stall);

  // R10
  halt_ignores_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arch_load && rst_lvl && wait_req) |=> arch_load);

endmodule

// File: rtl/rst_wait_ctrl.sv
module rst_wait_ctrl
  import rwc_pkg::*;
#(
  parameter int MIN_RST_CYCLES = 4,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              rst_pin,
  input  logic              test_pin,
  input  logic              wait_req,
  input  logic              irq_pending,
  output logic [WORD_W-1:0] flags_init,
  output logic [WORD_W-1:0] ip_init,
  output logic [WORD_W-1:0] cs_init,
  output logic [WORD_W-1:0] ds_init,
  output logic [WORD_W-1:0] ss_init,
  output logic [WORD_W-1:0] es_init,
  output logic              arch_load,
  output logic              queue_flush,
  output logic              fetch_start,
  output logic [PHYS_W-1:0] fetch_addr,
  output logic              core_stall
);

  logic rst_lvl;
  logic test_lvl;
  logic rst_accept;

  rwc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .d     (rst_pin),
    .q     (rst_lvl)
  );

  rwc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_test_sync (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .d     (test_pin),
    .q     (test_lvl)
  );

  rwc_qualifier #(.MIN_CYCLES(MIN_RST_CYCLES)) u_qual (
    .clk    (clk),
    .rst_n  (sys_rst_n),
    .lvl    (rst_lvl),
    .accept (rst_accept)
  );

  rwc_fsm u_fsm (
    .clk         (clk),
    .rst_n       (sys_rst_n),
    .rst_accept  (rst_accept),
    .rst_lvl     (rst_lvl),
    .test_lvl    (test_lvl),
    .wait_req    (wait_req),
    .irq_req     (irq_pending),
    .core_stall  (core_stall),
    .arch_load   (arch_load),
    .queue_flush (queue_flush),
    .fetch_start (fetch_start)
  );

  assign flags_init = FLAGS_INIT_VAL;
  assign ip_init    = IP_INIT_VAL;
  assign cs_init    = CS_INIT_VAL;
  assign ds_init    = DS_INIT_VAL;
  assign ss_init    = SS_INIT_VAL;
  assign es_init    = ES_INIT_VAL;
  assign fetch_addr = phys_addr(CS_INIT_VAL, IP_INIT_VAL);

  // R5
  fetch_vector_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    fetch_start |-> (fetch_addr == ((PHYS_W'(cs_init) << 4) + PHYS_W'(ip_init))));

  // R3
  halt_values_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    arch_load |-> (core_stall && flags_init == '0 && cs_init == '1));

endmodule

// File: tb/tb_rst_wait_ctrl.sv
`timescale 1ns/1ps
module tb_rst_wait_ctrl;

  localparam int MIN = 4;
  localparam int SYN = 2;
  localparam int ACC_EDGES = MIN + SYN;
  localparam int REL_EDGES = SYN + 1;
  localparam logic [19:0] EXP_VEC = (20'(16'hFFFF) * 20'd16) + 20'(16'h0000);

  logic clk = 1'b0;
  logic sys_rst_n, rst_pin, test_pin, wait_req, irq_pending;
  logic [15:0] flags_init, ip_init, cs_init, ds_init, ss_init, es_init;
  logic arch_load, queue_flush, fetch_start, core_stall;
  logic [19:0] fetch_addr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rst_wait_ctrl #(.MIN_RST_CYCLES(MIN), .SYNC_STAGES(SYN)) dut (
    .clk(clk), .sys_rst_n(sys_rst_n), .rst_pin(rst_pin), .test_pin(test_pin),
    .wait_req(wait_req), .irq_pending(irq_pending),
    .flags_init(flags_init), .ip_init(ip_init), .cs_init(cs_init),
    .ds_init(ds_init), .ss_init(ss_init), .es_init(es_init),
    .arch_load(arch_load), .queue_flush(queue_flush), .fetch_start(fetch_start),
    .fetch_addr(fetch_addr), .core_stall(core_stall)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk_values(input string req);
    chk(req, "flags", 32'(flags_init), 32'h0000);
    chk(req, "ip",    32'(ip_init),    32'h0000);
    chk(req, "cs",    32'(cs_init),    32'hFFFF);
    chk(req, "ds",    32'(ds_init),    32'h0000);
    chk(req, "ss",    32'(ss_init),    32'h0000);
    chk(req, "es",    32'(es_init),    32'h0000);
  endtask

  // R11, R3, R5: power-up halt, then release
  task automatic t_powerup();
    chk("R11", "stall at power-up", 32'(core_stall), 1);
    chk("R3", "load at power-up", 32'(arch_load), 1);
    chk_values("R3");
    tick(REL_EDGES - 1);
    chk("R11", "still halted", 32'(core_stall), 1);
    chk("R5", "no fetch yet", 32'(fetch_start), 0);
    tick(1);
    chk("R5", "fetch strobe", 32'(fetch_start), 1);
    chk("R5", "fetch address", 32'(fetch_addr), 32'(EXP_VEC));
    chk("R5", "stall released", 32'(core_stall), 0);
    tick(1);
    chk("R5", "fetch strobe single", 32'(fetch_start), 0);
  endtask

  // R2: short pulse while running
  task automatic t_short_run();
    int bad_stall = 0;
    int bad_flush = 0;
    rst_pin = 1'b1;
    tick(MIN - 1);
    rst_pin = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (core_stall) bad_stall++;
      if (queue_flush) bad_flush++;
      tick(1);
    end
    chk("R2", "stall cycles after short pulse", 32'(bad_stall), 0);
    chk("R2", "flush cycles after short pulse", 32'(bad_flush), 0);
  endtask

  // R1, R3, R4, R10, R5: full pulse, wait during halt, release
  task automatic t_accept();
    rst_pin = 1'b1;
    tick(ACC_EDGES - 1);
    chk("R1", "not accepted one edge early", 32'(core_stall), 0);
    tick(1);
    chk("R1", "accepted", 32'(core_stall), 1);
    chk("R4", "flush pulse", 32'(queue_flush), 1);
    chk("R3", "load in halt", 32'(arch_load), 1);
    chk_values("R3");
    tick(1);
    chk("R4", "flush ends", 32'(queue_flush), 0);
    wait_req = 1'b1;
    tick(1);
    wait_req = 1'b0;
    tick(2);
    chk("R10", "wait in halt keeps halt", 32'(arch_load), 1);
    rst_pin = 1'b0;
    tick(REL_EDGES - 1);
    chk("R5", "held until release edge", 32'(core_stall), 1);
    tick(1);
    chk("R5", "fetch on release", 32'(fetch_start), 1);
    chk("R10", "runs after release", 32'(core_stall), 0);
    tick(4);
    chk("R10", "wait during halt had no effect", 32'(core_stall), 0);
  endtask

  task automatic enter_idle(input string req);
    wait_req = 1'b1;
    tick(1);
    wait_req = 1'b0;
    chk(req, "idle stall", 32'(core_stall), 1);
  endtask

  // R6, R7
  task automatic t_wait_test();
    enter_idle("R6");
    tick(3);
    chk("R6", "idle holds", 32'(core_stall), 1);
    test_pin = 1'b0;
    tick(REL_EDGES - 1);
    chk("R7", "still idle before sync", 32'(core_stall), 1);
    tick(1);
    chk("R7", "test low ends idle", 32'(core_stall), 0);
    test_pin = 1'b1;
    tick(SYN + 1);
  endtask

  // R8
  task automatic t_wait_irq();
    enter_idle("R8");
    irq_pending = 1'b1;
    tick(1);
    chk("R8", "irq releases stall", 32'(core_stall), 0);
    tick(3);
    chk("R8", "no re-entry without strobe", 32'(core_stall), 0);
    irq_pending = 1'b0;
    tick(1);
    chk("R8", "no re-entry after irq", 32'(core_stall), 0);
    enter_idle("R8");
    test_pin = 1'b0;
    tick(REL_EDGES);
    chk("R8", "second idle ended by test", 32'(core_stall), 0);
  endtask

  // R9 (test still low here)
  task automatic t_wait_test_low();
    wait_req = 1'b1;
    tick(1);
    wait_req = 1'b0;
    chk("R9", "no stall with test low", 32'(core_stall), 0);
    tick(2);
    chk("R9", "still running", 32'(core_stall), 0);
    test_pin = 1'b1;
    tick(SYN + 1);
  endtask

  // R2 during idle, R10 reset overrides idle
  task automatic t_reset_in_idle();
    int bad = 0;
    enter_idle("R10");
    rst_pin = 1'b1;
    tick(MIN - 1);
    rst_pin = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (!core_stall || queue_flush || arch_load) bad++;
      tick(1);
    end
    chk("R2", "idle kept through short pulse", 32'(bad), 0);
    rst_pin = 1'b1;
    tick(ACC_EDGES);
    chk("R10", "reset overrides idle", 32'(arch_load), 1);
    chk("R4", "flush from idle", 32'(queue_flush), 1);
    rst_pin = 1'b0;
    tick(REL_EDGES);
    chk("R10", "runs after release", 32'(core_stall), 0);
    tick(5);
    chk("R10", "not back in idle", 32'(core_stall), 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    sys_rst_n = 1'b0;
    rst_pin = 1'b0;
    test_pin = 1'b1;
    wait_req = 1'b0;
    irq_pending = 1'b0;
    tick(3);
    sys_rst_n = 1'b1;
    t_powerup();
    t_short_run();
    t_accept();
    t_wait_test();
    t_wait_irq();
    t_wait_test_low();
    t_reset_in_idle();
    finish_sim();
  end

endmodule